// File: doc/BRIEF.md
# Six-Channel Register-Programmed DMA Engine

This block moves data between memory locations on behalf of software. Each channel is set up through a 32-bit register port. Software writes a source address, a destination address, a length counted in transfer units and a command word that picks the access width and the unit size. It then sets the channel's run bits. A single shared engine carries out each unit as a chain of single-beat read/write pairs on a simple memory master port. When a channel's count reaches zero, the channel marks itself finished and can raise an interrupt.

A global control word gates every channel at once. A global interrupt word shows one pending bit per channel. When several channels are ready, the lowest-numbered one wins, and a new choice is made only between units. Register reads are combinational. Register writes take effect at the clock edge on which `reg_we_i` is high.

Top module: `regdma_top`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `mem_req_o` is 0.
- R2: Channel c's registers sit at byte offset c*0x20 plus: source 0x00, destination 0x04, count 0x08, request type 0x0C, status 0x10, command 0x14, descriptor address 0x18. Global control is at 0x300 and interrupt status at 0x304. Status keeps only bits 31,6,4..0 (mask 0x8000005F). Command keeps only bits 23,22,15..12,10..8,7,1 (mask 0x00C0F782). Global control keeps only bits 9..8,3,2,0 (mask 0x30D). Request type and descriptor address keep all 32 bits.
- R3: A channel issues memory accesses only when all of these hold: its status bit 0 (enable) is 1, its status bit 31 (no-descriptor) is 1, its status bit 2 (halt) is 0, global bit 0 (enable) is 1 and global bit 3 (halt) is 0.
- R4: Each beat is one read at the source address followed by one write of the same data at the destination address. Both accesses use the source width from command bits 15:14, where 0=32-bit, 1=8-bit and 2=16-bit. `mem_size_o` gives the width as 0=byte, 1=halfword, 2=word.
- R5: Command bits 10:8 give the unit size: 0=4, 1=1, 2=2, 3=16, 4=32 bytes, and other codes mean 1 byte. A unit takes unit/width beats, with a minimum of 1. The count drops by one per completed unit.
- R6: Command bit 23 makes the source address advance by the width in bytes after every beat. Command bit 22 does the same for the destination. With a bit clear, that address stays fixed.
- R7: When the count reaches zero, status bit 3 (done) is set and the channel issues no further accesses.
- R8: Interrupt status bit c is channel c's done bit ANDed with its command bit 1. `irq_o` is the OR of those bits. Writing a status word with bit 3 clear drops the pending bit.
- R9: The lowest-numbered ready channel is served first. A channel that becomes ready mid-unit waits for that unit's last write to finish.
- R10: While a channel runs, reading its count returns the number of units not yet completed.
- R11: Once `mem_req_o` is raised, it stays high with the same address, direction and write data until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register word address (byte address bits 9:2) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_size_o | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, taken with `mem_ack_i` |
| mem_ack_i | input | 1 | Access complete |
| irq_o | output | 1 | OR of all pending interrupt bits |

## Verification
Errors in the beat counter or in address stepping show up at once in the logged address and size sequence of the very next unit. The count of accesses per transfer then comes out wrong. A count register that drifts is caught by sampling it mid-run against the number of writes already seen. A wrong done or pending state shows up when the transfer ends, at the interrupt word and on `irq_o`. A wrong arbitration decision shows up as the first access of a unit carrying the wrong channel's address region, within one unit time.

// File: rtl/regdma_pkg.sv
package regdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;

  localparam int SC_EN     = 0;
  localparam int SC_HALT   = 2;
  localparam int SC_DONE   = 3;
  localparam int SC_NODESC = 31;
  localparam int CM_SINC   = 23;
  localparam int CM_DINC   = 22;
  localparam int CM_IRQ    = 1;
  localparam int GC_EN     = 0;
  localparam int GC_HALT   = 3;

  localparam logic [31:0] SC_MASK = 32'h8000_005F;
  localparam logic [31:0] CM_MASK = 32'h00C0_F782;
  localparam logic [31:0] GC_MASK = 32'h0000_030D;

  localparam logic [2:0] IX_SRC  = 3'd0;
  localparam logic [2:0] IX_DST  = 3'd1;
  localparam logic [2:0] IX_CNT  = 3'd2;
  localparam logic [2:0] IX_REQ  = 3'd3;
  localparam logic [2:0] IX_STAT = 3'd4;
  localparam logic [2:0] IX_CMD  = 3'd5;
  localparam logic [2:0] IX_DESC = 3'd6;

  // log2 of access bytes; doubles as bus size code
  function automatic logic [1:0] width_shift(input logic [1:0] w);
    case (w)
      2'd1:    return 2'd0;
      2'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] unit_shift(input logic [2:0] u);
    case (u)
      3'd0:    return 3'd2;
      3'd2:    return 3'd1;
      3'd3:    return 3'd4;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [5:0] beats_m1(input logic [1:0] w, input logic [2:0] u);
    logic [2:0] ws;
    logic [2:0] us;
    ws = {1'b0, width_shift(w)};
    us = unit_shift(u);
    if (us > ws) return (6'd1 << (us - ws)) - 6'd1;
    return 6'd0;
  endfunction
endpackage

// File: rtl/regdma_chan_regs.sv
module regdma_chan_regs import regdma_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_we_i,
  input  logic [2:0]    sw_idx_i,
  input  logic [31:0]   sw_wdata_i,
  output logic [31:0]   sw_rdata_o,
  input  logic          beat_i,
  input  logic          unit_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    width_o,
  output logic [2:0]    usize_o,
  output logic          ready_o,
  output logic          done_o,
  output logic          irq_en_o
);
  logic [AW-1:0] src_q, dst_q, step;
  logic [CW-1:0] cnt_q;
  logic [31:0]   req_q, stat_q, cmd_q, desc_q;
  logic wr_src, wr_dst, wr_cnt, wr_req, wr_stat, wr_cmd, wr_desc;

  assign wr_src  = sw_we_i && (sw_idx_i == IX_SRC);
  assign wr_dst  = sw_we_i && (sw_idx_i == IX_DST);
  assign wr_cnt  = sw_we_i && (sw_idx_i == IX_CNT);
  assign wr_req  = sw_we_i && (sw_idx_i == IX_REQ);
  assign wr_stat = sw_we_i && (sw_idx_i == IX_STAT);
  assign wr_cmd  = sw_we_i && (sw_idx_i == IX_CMD);
  assign wr_desc = sw_we_i && (sw_idx_i == IX_DESC);

  assign step = AW'(1) << width_shift(cmd_q[15:14]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      req_q  <= '0;
      stat_q <= '0;
      cmd_q  <= '0;
      desc_q <= '0;
    end else begin
      // software write wins over engine update in the same cycle
      if (wr_src) src_q <= sw_wdata_i[AW-1:0];
      else if (beat_i && cmd_q[CM_SINC]) src_q <= src_q + step;
      if (wr_dst) dst_q <= sw_wdata_i[AW-1:0];
      else if (beat_i && cmd_q[CM_DINC]) dst_q <= dst_q + step;
      if (wr_cnt) cnt_q <= sw_wdata_i[CW-1:0];
      else if (unit_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      if (wr_req)  req_q  <= sw_wdata_i;
      if (wr_cmd)  cmd_q  <= sw_wdata_i & CM_MASK;
      if (wr_desc) desc_q <= sw_wdata_i;
      if (wr_stat) stat_q <= sw_wdata_i & SC_MASK;
      else if (unit_i && cnt_q == CW'(1)) stat_q[SC_DONE] <= 1'b1;
    end
  end

  always_comb begin
    case (sw_idx_i)
      IX_SRC:  sw_rdata_o = 32'(src_q);
      IX_DST:  sw_rdata_o = 32'(dst_q);
      IX_CNT:  sw_rdata_o = 32'(cnt_q);
      IX_REQ:  sw_rdata_o = req_q;
      IX_STAT: sw_rdata_o = stat_q;
      IX_CMD:  sw_rdata_o = cmd_q;
      IX_DESC: sw_rdata_o = desc_q;
      default: sw_rdata_o = '0;
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign width_o  = cmd_q[15:14];
  assign usize_o  = cmd_q[10:8];
  assign done_o   = stat_q[SC_DONE];
  assign irq_en_o = cmd_q[CM_IRQ];
  assign ready_o  = stat_q[SC_EN] && stat_q[SC_NODESC] && !stat_q[SC_HALT] &&
                    !stat_q[SC_DONE] && (cnt_q != '0);

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i && !wr_cnt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_done_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_i && !wr_stat && cnt_q == CW'(1)) |=> stat_q[SC_DONE]);
endmodule

// File: rtl/regdma_engine.sv
module regdma_engine import regdma_pkg::*; #(
  parameter int N_CH = 6,
  parameter int AW   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [N_CH-1:0]          ready_i,
  input  logic [N_CH-1:0][AW-1:0]  src_i,
  input  logic [N_CH-1:0][AW-1:0]  dst_i,
  input  logic [N_CH-1:0][1:0]     width_i,
  input  logic [N_CH-1:0][2:0]     usize_i,
  output logic [N_CH-1:0]          beat_o,
  output logic [N_CH-1:0]          unit_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [1:0]               mem_size_o,
  output logic [31:0]              mem_wdata_o,
  input  logic [31:0]              mem_rdata_i,
  input  logic                     mem_ack_i
);
  localparam int SW = (N_CH > 1) ? $clog2(N_CH) : 1;

  eng_st_e         st_q;
  logic [SW-1:0]   sel_q, pick;
  logic            any;
  logic [5:0]      beat_q;
  logic [31:0]     data_q;
  logic            wr_done;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (ready_i[i]) begin
        pick = SW'(i);
        any  = 1'b1;
      end
    end
  end

  assign wr_done = (st_q == ST_WR) && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      beat_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i && any) begin
          sel_q  <= pick;
          beat_q <= beats_m1(width_i[pick], usize_i[pick]);
          st_q   <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          data_q <= mem_rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_ack_i) begin
          if (beat_q == '0) st_q <= ST_IDLE;
          else begin
            beat_q <= beat_q - 6'd1;
            st_q   <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_pulse
    assign beat_o[i] = wr_done && (sel_q == SW'(i));
    assign unit_o[i] = beat_o[i] && (beat_q == '0);
  end

  assign mem_req_o   = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? dst_i[sel_q] : src_i[sel_q];
  assign mem_size_o  = width_shift(width_i[sel_q]);
  assign mem_wdata_o = data_q;

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_sel_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(sel_q));
endmodule

// File: rtl/regdma_top.sv
module regdma_top import regdma_pkg::*; #(
  parameter int N_CH = 6,
  parameter int AW   = 32,
  parameter int CW   = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [9:2]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          irq_o
);
  localparam logic [9:0] GCTL_OFS = 10'h300;
  localparam logic [9:0] IRQ_OFS  = 10'h304;

  logic [2:0]  ch_field, idx;
  logic        ch_hit;
  logic [9:0]  byte_ofs;
  logic [31:0] gctl_q;

  logic [N_CH-1:0][31:0]   ch_rdata;
  logic [N_CH-1:0][AW-1:0] src, dst;
  logic [N_CH-1:0][1:0]    width;
  logic [N_CH-1:0][2:0]    usize;
  logic [N_CH-1:0]         ready, done, irq_en, beat, unit, irq_stat;

  assign byte_ofs = {reg_addr_i, 2'b00};
  assign ch_field = reg_addr_i[7:5];
  assign idx      = reg_addr_i[4:2];
  assign ch_hit   = (reg_addr_i[9:8] == 2'b00) && (int'(ch_field) < N_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gctl_q <= '0;
    else if (reg_we_i && byte_ofs == GCTL_OFS) gctl_q <= reg_wdata_i & GC_MASK;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    regdma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sw_we_i    (reg_we_i && ch_hit && (ch_field == 3'(i))),
      .sw_idx_i   (idx),
      .sw_wdata_i (reg_wdata_i),
      .sw_rdata_o (ch_rdata[i]),
      .beat_i     (beat[i]),
      .unit_i     (unit[i]),
      .src_o      (src[i]),
      .dst_o      (dst[i]),
      .width_o    (width[i]),
      .usize_o    (usize[i]),
      .ready_o    (ready[i]),
      .done_o     (done[i]),
      .irq_en_o   (irq_en[i])
    );
  end

  assign irq_stat = done & irq_en;
  assign irq_o    = |irq_stat;

  always_comb begin
    reg_rdata_o = '0;
    if (ch_hit) reg_rdata_o = ch_rdata[ch_field];
    else if (byte_ofs == GCTL_OFS) reg_rdata_o = gctl_q;
    else if (byte_ofs == IRQ_OFS) reg_rdata_o = 32'(irq_stat);
  end

  regdma_engine #(.N_CH(N_CH), .AW(AW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (gctl_q[GC_EN] && !gctl_q[GC_HALT]),
    .ready_i     (ready),
    .src_i       (src),
    .dst_i       (dst),
    .width_i     (width),
    .usize_i     (usize),
    .beat_o      (beat),
    .unit_o      (unit),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i)
  );
endmodule

// File: tb/regdma_top_bench.sv
module regdma_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [9:2]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, irq;
  logic        mem_ack = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  int n_chk = 0, n_fail = 0;

  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

  regdma_top u_regdma_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  // memory model with programmable latency
  int lat = 0, wcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mem_ack <= 1'b0; wcnt <= 0; end
    else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin mem_ack <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else mem_ack <= 1'b0;
  end

  logic        lg_we[1024];
  logic [31:0] lg_addr[1024], lg_data[1024];
  logic [1:0]  lg_size[1024];
  int n_log = 0;
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack && n_log < 1024) begin
      lg_we[n_log] = mem_we; lg_addr[n_log] = mem_addr; lg_size[n_log] = mem_size;
      lg_data[n_log] = mem_we ? mem_wdata : mem_rdata;
      n_log++;
    end
  end

  // handshake monitor (R11)
  logic p_wait = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_data = '0;
  int hs_viol = 0;
  always @(posedge clk) begin
    if (p_wait && (!mem_req || mem_addr != p_addr || mem_we != p_we || (p_we && mem_wdata != p_data)))
      hs_viol++;
    p_wait = rst_n && mem_req && !mem_ack;
    p_addr = mem_addr; p_we = mem_we; p_data = mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a[9:2]; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a[9:2]; #1; d = reg_rdata;
  endtask

  function automatic logic [9:0] ra(input int ch, input int ix);
    return 10'(ch * 32 + ix * 4);
  endfunction

  task automatic wait_done(input int ch, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      rd(ra(ch, 4), s);
      if (s[3]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic int wbytes(input logic [1:0] w);
    return (w == 2'd1) ? 1 : (w == 2'd2) ? 2 : 4;
  endfunction
  function automatic logic [1:0] wsize(input logic [1:0] w);
    return (w == 2'd1) ? 2'd0 : (w == 2'd2) ? 2'd1 : 2'd2;
  endfunction
  function automatic int ubytes(input logic [2:0] u);
    case (u) 3'd0: return 4; 3'd2: return 2; 3'd3: return 16; 3'd4: return 32; default: return 1; endcase
  endfunction

  // {sinc, dinc, irq_en, width[1:0], unit[2:0], count[7:0], src[15:0], dst[15:0]}
  localparam logic [47:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b1, 2'd0, 3'd0, 8'd3, 16'h1000, 16'h2000},
    {1'b1, 1'b0, 1'b0, 2'd1, 3'd0, 8'd2, 16'h1100, 16'h2100},
    {1'b0, 1'b1, 1'b1, 2'd2, 3'd3, 8'd1, 16'h1200, 16'h2200},
    {1'b1, 1'b1, 1'b0, 2'd0, 3'd1, 8'd2, 16'h1300, 16'h2300},
    {1'b0, 1'b0, 1'b1, 2'd0, 3'd4, 8'd1, 16'h1400, 16'h2400},
    {1'b1, 1'b1, 1'b1, 2'd1, 3'd2, 8'd3, 16'h1500, 16'h2500}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, bad, beats, total, wb, w_seen;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ra(0, 0), v); check(v == 0, "R1 src0", v, 0);
    rd(ra(5, 5), v); check(v == 0, "R1 cmd5", v, 0);
    rd(10'h300, v);  check(v == 0, "R1 gctl", v, 0);
    rd(10'h304, v);  check(v == 0, "R1 irqstat", v, 0);
    check(!irq && !mem_req, "R1 outputs", {30'b0, irq, mem_req}, 0);

    // R2 map and masks
    wr(ra(3, 0), 32'hDEAD_BEE0); rd(ra(3, 0), v); check(v == 32'hDEAD_BEE0, "R2 src3", v, 32'hDEAD_BEE0);
    wr(ra(3, 6), 32'h1234_5678); rd(ra(3, 6), v); check(v == 32'h1234_5678, "R2 desc3", v, 32'h1234_5678);
    wr(ra(5, 3), 32'h0000_0015); rd(ra(5, 3), v); check(v == 32'h15, "R2 reqtype5", v, 32'h15);
    wr(ra(3, 5), 32'hFFFF_FFFF); rd(ra(3, 5), v); check(v == 32'h00C0_F782, "R2 cmd mask", v, 32'h00C0_F782);
    wr(ra(2, 4), 32'hFFFF_FFFF); rd(ra(2, 4), v); check(v == 32'h8000_005F, "R2 status mask", v, 32'h8000_005F);
    wr(ra(2, 4), 0);
    wr(ra(3, 5), 0);
    wr(10'h300, 32'hFFFF_FFFF); rd(10'h300, v); check(v == 32'h30D, "R2 gctl mask", v, 32'h30D);
    wr(10'h300, 32'h1);

    // vector table: R4 R5 R6 R7 R8 R11
    for (int c = 0; c < 6; c++) begin
      logic [47:0] e;
      e = VEC[c];
      lat = c % 3;
      base = n_log;
      wr(ra(0, 0), {16'h0, e[31:16]});
      wr(ra(0, 1), {16'h0, e[15:0]});
      wr(ra(0, 2), {24'h0, e[39:32]});
      wr(ra(0, 5), (32'(e[47]) << 23) | (32'(e[46]) << 22) | (32'(e[44:43]) << 14) |
                   (32'(e[44:43]) << 12) | (32'(e[42:40]) << 8) | (32'(e[45]) << 1));
      wr(ra(0, 4), 32'h8000_0001);
      wait_done(0, ok);
      check(ok, "R7 done reached", 32'(ok), 1);
      wb = wbytes(e[44:43]);
      beats = (ubytes(e[42:40]) > wb) ? ubytes(e[42:40]) / wb : 1;
      total = beats * int'(e[39:32]);
      check(n_log - base == 2 * total, "R5 access count", 32'(n_log - base), 32'(2 * total));
      bad = 0;
      for (int k = 0; k < total && base + 2 * k + 1 < n_log; k++) begin
        logic [31:0] ea_r, ea_w;
        ea_r = {16'h0, e[31:16]} + (e[47] ? 32'(k * wb) : 0);
        ea_w = {16'h0, e[15:0]}  + (e[46] ? 32'(k * wb) : 0);
        if (lg_we[base+2*k] || lg_addr[base+2*k] != ea_r || lg_size[base+2*k] != wsize(e[44:43]) ||
            !lg_we[base+2*k+1] || lg_addr[base+2*k+1] != ea_w || lg_size[base+2*k+1] != wsize(e[44:43]) ||
            lg_data[base+2*k+1] != lg_data[base+2*k]) begin
          if (bad == 0) $display("FAIL R4/R6 beat %0d actual=%h expected=%h", k, lg_addr[base+2*k], ea_r);
          bad++;
        end
      end
      n_chk++; if (bad != 0) n_fail++;
      rd(ra(0, 2), v); check(v == 0, "R7 count zero", v, 0);
      rd(ra(0, 4), v); check(v == 32'h8000_0009, "R7 status done", v, 32'h8000_0009);
      rd(10'h304, v); check(v == 32'(e[45]) && irq == e[45], "R8 pending", v, 32'(e[45]));
      wr(ra(0, 4), 0);
      rd(10'h304, v); check(v == 0 && !irq, "R8 clear", v, 0);
      base = n_log; repeat (10) @(negedge clk);
      check(n_log == base, "R7 no access after done", 32'(n_log - base), 0);
    end
    lat = 0;

    // R3 gating
    wr(ra(1, 0), 32'h6000); wr(ra(1, 1), 32'h6800); wr(ra(1, 2), 4); wr(ra(1, 5), 32'h00C0_0000);
    base = n_log;
    wr(ra(1, 4), 32'h0000_0001); repeat (40) @(negedge clk);
    rd(ra(1, 2), v); check(n_log == base && v == 4, "R3 no-descriptor clear", 32'(n_log - base), 0);
    wr(ra(1, 4), 32'h8000_0005); repeat (40) @(negedge clk);
    rd(ra(1, 2), v); check(n_log == base && v == 4, "R3 channel halt", 32'(n_log - base), 0);
    wr(10'h300, 32'h9); wr(ra(1, 4), 32'h8000_0001); repeat (40) @(negedge clk);
    check(n_log == base, "R3 global halt", 32'(n_log - base), 0);
    wr(10'h300, 32'h0); repeat (40) @(negedge clk);
    check(n_log == base, "R3 global enable clear", 32'(n_log - base), 0);
    wr(10'h300, 32'h1); wait_done(1, ok);
    check(ok && n_log - base == 8, "R3 runs when gated on", 32'(n_log - base), 8);
    wr(ra(1, 4), 0);

    // R9 simultaneous ready
    wr(10'h300, 0);
    wr(ra(4, 0), 32'h4000); wr(ra(4, 1), 32'h4800); wr(ra(4, 2), 2); wr(ra(4, 5), 32'h00C0_0000);
    wr(ra(2, 0), 32'h3000); wr(ra(2, 1), 32'h3800); wr(ra(2, 2), 2); wr(ra(2, 5), 32'h00C0_0000);
    wr(ra(4, 4), 32'h8000_0001); wr(ra(2, 4), 32'h8000_0001);
    base = n_log;
    wr(10'h300, 1);
    wait_done(4, ok);
    bad = 0;
    for (int k = 0; k < 8; k++)
      if (base + k >= n_log || lg_addr[base+k][15:12] != ((k < 4) ? 4'h3 : 4'h4)) bad++;
    check(bad == 0, "R9 lowest first", 32'(bad), 0);
    wr(ra(4, 4), 0); wr(ra(2, 4), 0);

    // R9 switch only at unit boundary
    lat = 1;
    wr(ra(4, 0), 32'h4000); wr(ra(4, 1), 32'h4800); wr(ra(4, 2), 3); wr(ra(4, 5), 32'h00C0_0300);
    wr(ra(1, 0), 32'h5000); wr(ra(1, 1), 32'h5800); wr(ra(1, 2), 1); wr(ra(1, 5), 32'h00C0_0300);
    base = n_log;
    wr(ra(4, 4), 32'h8000_0001);
    while (n_log == base) @(negedge clk);
    wr(ra(1, 4), 32'h8000_0001);
    wait_done(4, ok);
    bad = 0;
    for (int k = 0; k < 32; k++)
      if (base + k >= n_log || lg_addr[base+k][15:12] != ((k >= 8 && k < 16) ? 4'h5 : 4'h4)) bad++;
    check(bad == 0 && n_log - base == 32, "R9 unit boundary", 32'(bad), 0);
    wr(ra(4, 4), 0); wr(ra(1, 4), 0);

    // R10 live count
    lat = 2;
    wr(ra(0, 0), 32'h7000); wr(ra(0, 1), 32'h7800); wr(ra(0, 2), 20); wr(ra(0, 5), 32'h00C0_0000);
    base = n_log;
    wr(ra(0, 4), 32'h8000_0001);
    w_seen = 0;
    while (w_seen < 5) begin
      @(negedge clk);
      w_seen = 0;
      for (int k = base; k < n_log; k++) if (lg_we[k]) w_seen++;
    end
    rd(ra(0, 2), v);
    w_seen = 0;
    for (int k = base; k < n_log; k++) if (lg_we[k]) w_seen++;
    check(v == 32'(20 - w_seen), "R10 remaining units", v, 32'(20 - w_seen));
    wait_done(0, ok);
    check(ok && n_log - base == 40, "R10 completes", 32'(n_log - base), 40);
    wr(ra(0, 4), 0);

    check(hs_viol == 0, "R11 request held until ack", 32'(hs_viol), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule